// File: doc/BRIEF.md
# Per-CPU Interrupt Acknowledge Interface

This block sits between an interrupt distribution stage and one processor. Each cycle it takes a vector of set-pending pulses, an eligibility vector (the lines that are enabled and routed to this processor), and one priority byte per line. It keeps its own pending and active state for every line. Among the lines that are pending, eligible and not already active, it picks a winner and raises a request to the processor when that winner's priority clears a programmable threshold.

Software reaches the block through a small register bus with four word slots, selected by a 2-bit address. Reading the acknowledge slot returns the winning line number. The same read claims the interrupt by moving it from pending to active, and the request then follows the next candidate. Writing a line number to the end-of-interrupt slot releases it. Preemption and interrupt grouping are not modelled.

Top module: `aif_cpu_if`

## Requirements
- R1: After reset the request is low, the control and threshold registers read as zero, no line is pending or active, and an acknowledge read returns 1023.
- R2: Address 0 holds the control register. Bit 0 enables signalling and reads back in bit 0, with the other bits zero. While bit 0 is clear the request stays low.
- R3: Address 1 holds an 8-bit priority threshold that reads back in bits 7:0. The request is raised only when the winner's priority value is strictly lower than the threshold.
- R4: The winner is the candidate with the numerically lowest priority value. A lower value means more urgent. When priorities are equal, the lowest line number wins.
- R5: A read of address 2 while the request is high returns the winner's line number in bits 9:0, with bits 31:10 zero. On that clock edge the line leaves pending and becomes active. From the next cycle the request reflects the next candidate.
- R6: A read of address 2 while the request is low returns 1023 and changes no pending or active state.
- R7: An active line is never offered. A write to address 3 clears the active state of the line whose number is in bits 9:0. A write naming a number at or above the line count, including 1020 to 1023, has no effect.
- R8: If a line's set-pending pulse arrives in the same cycle as the acknowledge that claims it, the line ends that cycle both active and pending. It is offered again once its end-of-interrupt write arrives.
- R9: A pending line whose eligibility bit is low is not a candidate, but it stays pending. It is offered once its eligibility bit returns high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| set_pend | input | NUM_IRQ | One-cycle pulses that mark lines pending |
| line_elig | input | NUM_IRQ | Per-line enabled-and-targeted qualifier |
| line_prio | input | NUM_IRQ*8 | Priority byte of line i in bits 8i+7:8i |
| bus_rd | input | 1 | Register read strobe |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register slot: 0 control, 1 threshold, 2 acknowledge, 3 end-of-interrupt |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of bus_rd, zero otherwise |
| irq_req | output | 1 | Interrupt request to the processor |

## Verification
The acknowledge that claims a line and a new set-pending pulse for that same line can land in one cycle. The bench provokes this by driving the pulse together with the acknowledge read of the current winner. It then checks that the line stays silent while active, and that it reappears right after its end-of-interrupt write. A second overlap happens when a new, more urgent line arrives in the cycle of an acknowledge. The reference model has to agree on which line was returned and on which line the request follows one cycle later.

// File: rtl/aif_pkg.sv
package aif_pkg;
   localparam int          ID_W        = 10;
   localparam logic [9:0]  SPURIOUS_ID = 10'd1023;
   localparam int          PRIO_W      = 8;

   typedef enum logic [1:0] {
      SLOT_CTRL  = 2'd0,
      SLOT_THRES = 2'd1,
      SLOT_CLAIM = 2'd2,
      SLOT_DONE  = 2'd3
   } slot_e;
endpackage

// File: rtl/aif_arbiter.sv
module aif_arbiter #(
   parameter int NUM_IRQ   = 16,
   parameter int PRIO_BITS = 8,
   parameter int IDX_W     = 4
) (
   input  logic [NUM_IRQ-1:0]          cand,
   input  logic [NUM_IRQ*8-1:0]        prio_flat,
   output logic                        found,
   output logic [IDX_W-1:0]            win_idx,
   output logic [7:0]                  win_prio
);
   localparam int DROP = 8 - PRIO_BITS;

   logic [7:0] eff_prio [NUM_IRQ];

   genvar gi;
   generate
      for (gi = 0; gi < NUM_IRQ; gi++) begin : g_line
         if (DROP == 0) begin : g_full
            assign eff_prio[gi] = prio_flat[gi*8 +: 8];
         end else begin : g_trunc
            assign eff_prio[gi] = {prio_flat[gi*8+DROP +: PRIO_BITS], {DROP{1'b0}}};
         end
      end
   endgenerate

   always_comb begin
      found    = 1'b0;
      win_idx  = '0;
      win_prio = 8'hFF;
      for (int i = 0; i < NUM_IRQ; i++) begin
         if (cand[i] && (!found || (eff_prio[i] < win_prio))) begin
            found    = 1'b1;
            win_idx  = IDX_W'(i);
            win_prio = eff_prio[i];
         end
      end
   end
endmodule

// File: rtl/aif_state.sv
module aif_state #(
   parameter int NUM_IRQ = 16,
   parameter int IDX_W   = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_IRQ-1:0] set_pend,
   input  logic               take,
   input  logic [IDX_W-1:0]   take_idx,
   input  logic               done,
   input  logic [IDX_W-1:0]   done_idx,
   output logic [NUM_IRQ-1:0] pend_q,
   output logic [NUM_IRQ-1:0] act_q
);
   genvar gi;
   generate
      for (gi = 0; gi < NUM_IRQ; gi++) begin : g_bit
         logic hit_take;
         logic hit_done;
         assign hit_take = take && (take_idx == IDX_W'(gi));
         assign hit_done = done && (done_idx == IDX_W'(gi));

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               pend_q[gi] <= 1'b0;
               act_q[gi]  <= 1'b0;
            end else begin
               if (set_pend[gi])      pend_q[gi] <= 1'b1;
               else if (hit_take)     pend_q[gi] <= 1'b0;
               if (hit_take)          act_q[gi]  <= 1'b1;
               else if (hit_done)     act_q[gi]  <= 1'b0;
            end
         end
      end
   endgenerate
endmodule

// File: rtl/aif_regs.sv
module aif_regs
   import aif_pkg::*;
#(
   parameter int NUM_IRQ = 16,
   parameter int IDX_W   = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bus_rd,
   input  logic             bus_wr,
   input  logic [1:0]       bus_addr,
   input  logic [31:0]      bus_wdata,
   input  logic [ID_W-1:0]  claim_id,
   output logic [31:0]      bus_rdata,
   output logic             ctrl_en,
   output logic [7:0]       thres,
   output logic             claim_rd,
   output logic             done,
   output logic [IDX_W-1:0] done_idx
);
   slot_e slot;
   assign slot = slot_e'(bus_addr);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_en <= 1'b0;
         thres   <= 8'h00;
      end else if (bus_wr) begin
         if (slot == SLOT_CTRL)  ctrl_en <= bus_wdata[0];
         if (slot == SLOT_THRES) thres   <= bus_wdata[7:0];
      end
   end

   assign claim_rd = bus_rd && !bus_wr && (slot == SLOT_CLAIM);
   assign done     = bus_wr && (slot == SLOT_DONE) &&
                     (bus_wdata[ID_W-1:0] < ID_W'(NUM_IRQ));
   assign done_idx = bus_wdata[IDX_W-1:0];

   always_comb begin
      bus_rdata = '0;
      if (bus_rd) begin
         unique case (slot)
            SLOT_CTRL:  bus_rdata[0]      = ctrl_en;
            SLOT_THRES: bus_rdata[7:0]    = thres;
            SLOT_CLAIM: bus_rdata[ID_W-1:0] = claim_id;
            SLOT_DONE:  bus_rdata         = '0;
         endcase
      end
   end
endmodule

// File: rtl/aif_cpu_if.sv
module aif_cpu_if
   import aif_pkg::*;
#(
   parameter int NUM_IRQ   = 16,
   parameter int PRIO_BITS = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_IRQ-1:0]   set_pend,
   input  logic [NUM_IRQ-1:0]   line_elig,
   input  logic [NUM_IRQ*8-1:0] line_prio,
   input  logic                 bus_rd,
   input  logic                 bus_wr,
   input  logic [1:0]           bus_addr,
   input  logic [31:0]          bus_wdata,
   output logic [31:0]          bus_rdata,
   output logic                 irq_req
);
   localparam int IDX_W = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1;

   initial begin
      assert (NUM_IRQ >= 1 && NUM_IRQ <= 1020)
         else $error("aif_cpu_if: NUM_IRQ out of range");
      assert (PRIO_BITS >= 1 && PRIO_BITS <= PRIO_W)
         else $error("aif_cpu_if: PRIO_BITS out of range");
   end

   logic [NUM_IRQ-1:0] pend_q, act_q, cand;
   logic               found;
   logic [IDX_W-1:0]   win_idx;
   logic [7:0]         win_prio;
   logic               ctrl_en;
   logic [7:0]         thres;
   logic               claim_rd, take, done;
   logic [IDX_W-1:0]   done_idx;
   logic [ID_W-1:0]    claim_id;

   assign cand = pend_q & line_elig & ~act_q;

   aif_arbiter #(.NUM_IRQ(NUM_IRQ), .PRIO_BITS(PRIO_BITS), .IDX_W(IDX_W)) u_arb (
      .cand(cand), .prio_flat(line_prio),
      .found(found), .win_idx(win_idx), .win_prio(win_prio)
   );

   assign irq_req  = ctrl_en && found && (win_prio < thres);
   assign claim_id = irq_req ? ID_W'(win_idx) : SPURIOUS_ID;
   assign take     = claim_rd && irq_req;

   aif_regs #(.NUM_IRQ(NUM_IRQ), .IDX_W(IDX_W)) u_regs (
      .clk(clk), .rst_n(rst_n),
      .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .claim_id(claim_id), .bus_rdata(bus_rdata),
      .ctrl_en(ctrl_en), .thres(thres),
      .claim_rd(claim_rd), .done(done), .done_idx(done_idx)
   );

   aif_state #(.NUM_IRQ(NUM_IRQ), .IDX_W(IDX_W)) u_state (
      .clk(clk), .rst_n(rst_n), .set_pend(set_pend),
      .take(take), .take_idx(win_idx),
      .done(done), .done_idx(done_idx),
      .pend_q(pend_q), .act_q(act_q)
   );
endmodule

// File: rtl/aif_cpu_if_chk.sv
module aif_cpu_if_chk #(
   parameter int NUM_IRQ = 16,
   parameter int IDX_W   = 4
) (
   input logic               clk,
   input logic               rst_n,
   input logic               bus_rd,
   input logic               bus_wr,
   input logic [1:0]         bus_addr,
   input logic [31:0]        bus_rdata,
   input logic               irq_req,
   input logic               ctrl_en,
   input logic [7:0]         thres,
   input logic [7:0]         win_prio,
   input logic [IDX_W-1:0]   win_idx,
   input logic [NUM_IRQ-1:0] act_q
);
   logic claim_rd;
   assign claim_rd = bus_rd && !bus_wr && (bus_addr == 2'd2);

   AST_REQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req |-> ctrl_en); // R2
   AST_REQ_UNDER_THRES: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req |-> (win_prio < thres)); // R3
   AST_CLAIM_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      claim_rd |-> (bus_rdata[31:10] == '0)); // R5
   AST_CLAIM_ACTIVATES: assert property (@(posedge clk) disable iff (!rst_n)
      (claim_rd && bus_rdata[9:0] != 10'd1023) |=> act_q[$past(bus_rdata[IDX_W-1:0])]); // R5
   AST_SPURIOUS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (claim_rd && bus_rdata[9:0] == 10'd1023) |=> $stable(act_q)); // R6
   AST_NO_ACTIVE_OFFER: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req |-> !act_q[win_idx]); // R7
   AST_ACTIVE_VIA_CLAIM: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(claim_rd) |-> ((act_q & ~$past(act_q)) == '0)); // R7
endmodule

bind aif_cpu_if aif_cpu_if_chk #(.NUM_IRQ(NUM_IRQ), .IDX_W(IDX_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_addr(bus_addr),
   .bus_rdata(bus_rdata), .irq_req(irq_req), .ctrl_en(ctrl_en), .thres(thres),
   .win_prio(win_prio), .win_idx(win_idx), .act_q(act_q)
);

// File: tb/tb_aif_cpu_if.sv
module tb_aif_cpu_if;
   localparam int CLK_P = 10;
   localparam int N     = 16;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic [N-1:0]   set_pend = '0;
   logic [N-1:0]   line_elig = '1;
   logic [N*8-1:0] line_prio = '0;
   logic           bus_rd = 1'b0, bus_wr = 1'b0;
   logic [1:0]     bus_addr = '0;
   logic [31:0]    bus_wdata = '0;
   logic [31:0]    bus_rdata;
   logic           irq_req;

   int checks = 0, fails = 0;
   bit finished = 0;

   logic [N-1:0] pend_m = '0, act_m = '0;
   logic         en_m = 1'b0;
   logic [7:0]   thr_m = 8'h00;

   always #(CLK_P/2) clk = ~clk;

   aif_cpu_if dut (
      .clk(clk), .rst_n(rst_n), .set_pend(set_pend), .line_elig(line_elig),
      .line_prio(line_prio), .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_req(irq_req)
   );

   task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   task automatic set_prio(int i, logic [7:0] p);
      line_prio[i*8 +: 8] = p;
   endtask

   // One bus cycle: compare with the model at the falling edge, advance the model at the rising edge.
   task automatic step(string tag, logic rd, logic wr, logic [1:0] a, logic [31:0] wd,
                       logic [N-1:0] sp, output logic [31:0] got);
      int   best;
      logic [7:0] bp;
      logic q;
      logic [31:0] exp_rd;
      bus_rd = rd; bus_wr = wr; bus_addr = a; bus_wdata = wd; set_pend = sp;
      @(negedge clk);
      best = -1; bp = 8'hFF;
      for (int i = 0; i < N; i++)
         if (pend_m[i] && line_elig[i] && !act_m[i] && (best < 0 || line_prio[i*8 +: 8] < bp)) begin
            best = i; bp = line_prio[i*8 +: 8];
         end
      q = en_m && (best >= 0) && (bp < thr_m);
      exp_rd = 0;
      if (rd) case (a)
         2'd0: exp_rd = {31'd0, en_m};
         2'd1: exp_rd = {24'd0, thr_m};
         2'd2: exp_rd = q ? best : 1023;
         default: exp_rd = 0;
      endcase
      got = bus_rdata;
      chk(tag, "irq_req", {31'd0, irq_req}, {31'd0, q});
      chk(tag, "rdata", bus_rdata, exp_rd);
      @(posedge clk);
      if (wr && a == 2'd0) en_m = wd[0];
      if (wr && a == 2'd1) thr_m = wd[7:0];
      if (wr && a == 2'd3 && wd[9:0] < N) act_m[wd[3:0]] = 1'b0;
      if (rd && !wr && a == 2'd2 && q) begin
         pend_m[best] = 1'b0;
         act_m[best]  = 1'b1;
      end
      pend_m = pend_m | sp;
      #1;
      bus_rd = 0; bus_wr = 0; set_pend = '0;
   endtask

   task automatic idle(string tag);
      logic [31:0] g;
      step(tag, 0, 0, 0, 0, '0, g);
   endtask

   task automatic claim(string tag, logic [31:0] exp);
      logic [31:0] g;
      step(tag, 1, 0, 2'd2, 0, '0, g);
      chk(tag, "claim id", g, exp);
   endtask

   task automatic wreg(string tag, logic [1:0] a, logic [31:0] d);
      logic [31:0] g;
      step(tag, 0, 1, a, d, '0, g);
   endtask

   task automatic pulse(string tag, logic [N-1:0] sp);
      logic [31:0] g;
      step(tag, 0, 0, 0, 0, sp, g);
   endtask

   initial begin
      #(CLK_P * 200000);
      if (!finished) begin
         fails++;
         $display("FAIL watchdog: actual running expected finished");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      logic [31:0] g;
      for (int i = 0; i < N; i++) set_prio(i, 8'h80);
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R1 reset state
      chk("R1", "irq_req", {31'd0, irq_req}, 0);
      step("R1", 1, 0, 2'd0, 0, '0, g); chk("R1", "ctrl", g, 0);
      step("R1", 1, 0, 2'd1, 0, '0, g); chk("R1", "thres", g, 0);
      claim("R1", 1023);

      // R2 / R3 program and read back
      wreg("R2", 2'd0, 32'hFFFF_FFFF);
      step("R2", 1, 0, 2'd0, 0, '0, g); chk("R2", "ctrl readback", g, 1);
      wreg("R3", 2'd1, 32'h1234_56F0);
      step("R3", 1, 0, 2'd1, 0, '0, g); chk("R3", "thres readback", g, 32'hF0);

      // R4 / R5 priority pick and claim
      set_prio(3, 8'h80); set_prio(5, 8'h40);
      pulse("R4", 16'h0028);
      idle("R4"); chk("R4", "req raised", {31'd0, irq_req}, 1);
      claim("R5", 5);
      claim("R5", 3);
      claim("R6", 1023);

      // R7 active line is not offered until released
      pulse("R7", 16'h0020);
      idle("R7"); chk("R7", "active not offered", {31'd0, irq_req}, 0);
      wreg("R7", 2'd3, 32'd1023);
      idle("R7"); chk("R7", "spurious release ignored", {31'd0, irq_req}, 0);
      wreg("R7", 2'd3, 32'd40);
      wreg("R7", 2'd3, 32'd5);
      idle("R7"); chk("R7", "reoffered after release", {31'd0, irq_req}, 1);
      claim("R7", 5);
      wreg("R7", 2'd3, 5); wreg("R7", 2'd3, 3);

      // R4 tie goes to lowest line
      set_prio(2, 8'h20); set_prio(7, 8'h20);
      pulse("R4", 16'h0084);
      claim("R4", 2);
      claim("R4", 7);
      wreg("R4", 2'd3, 2); wreg("R4", 2'd3, 7);

      // R3 threshold boundary
      set_prio(9, 8'hF0);
      pulse("R3", 16'h0200);
      idle("R3"); chk("R3", "equal to threshold blocked", {31'd0, irq_req}, 0);
      claim("R6", 1023);
      wreg("R3", 2'd1, 32'hF1);
      idle("R3"); chk("R3", "below threshold passes", {31'd0, irq_req}, 1);

      // R2 disable gates request, R6 claim has no effect
      wreg("R2", 2'd0, 0);
      idle("R2"); chk("R2", "disabled", {31'd0, irq_req}, 0);
      claim("R6", 1023);
      wreg("R2", 2'd0, 1);
      claim("R6", 9);
      wreg("R6", 2'd3, 9);

      // R9 ineligible line keeps pending
      set_prio(11, 8'h10);
      line_elig[11] = 1'b0;
      pulse("R9", 16'h0800);
      idle("R9"); chk("R9", "ineligible silent", {31'd0, irq_req}, 0);
      line_elig[11] = 1'b1;
      idle("R9"); chk("R9", "eligible again", {31'd0, irq_req}, 1);

      // R8 set-pending collides with the claim of the same line
      step("R8", 1, 0, 2'd2, 0, 16'h0800, g); chk("R8", "claim id", g, 11);
      idle("R8"); chk("R8", "held while active", {31'd0, irq_req}, 0);
      wreg("R8", 2'd3, 11);
      idle("R8"); chk("R8", "reoffered", {31'd0, irq_req}, 1);
      claim("R8", 11);
      wreg("R8", 2'd3, 11);

      // R5 a more urgent line arrives in the claim cycle
      set_prio(1, 8'h50); set_prio(0, 8'h05);
      pulse("R5", 16'h0002);
      step("R5", 1, 0, 2'd2, 0, 16'h0001, g); chk("R5", "claim id", g, 1);
      claim("R5", 0);
      claim("R6", 1023);

      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule